// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one SDRAM read or write burst request into the column address sequence the memory controller puts on the bus, one address per clock. A mode word, sampled together with a start strobe, sets how many beats the burst has, whether offsets are visited in counting order or by exclusive-or with the beat number, and whether writes are reduced to a single beat while reads keep the programmed length.

Fixed-length bursts move only the column bits inside their aligned window of 2, 4 or 8 columns; the bits above the window stay as given at start. A full-page burst steps through every column of the page, wraps at the page size, and runs until a terminate input stops it. A terminate also cuts a fixed burst short, and a new start during a burst drops the old one and begins again at the new column. The page width is a parameter of 8, 9 or 10 column bits.

The controller around the block drives a start strobe with a column and a read/write flag, then takes one address per clock from `col_out` while `col_valid` is high, using `col_last` to know when a fixed burst is over.

Top module: `sdram_burst_addr_gen`

## Requirements
- R1: The mode word length field `mode_word[2:0]` selects 1 beat (000), 2 (001), 4 (010), 8 (011) or full page (111); a fixed burst shows exactly that many valid beats on consecutive cycles starting the cycle after the start strobe, and `col_last` is high on the final beat only.
- R2: With `mode_word[3]` = 0 (counting order), beat k carries the low window bits (start offset + k) modulo the burst length.
- R3: With `mode_word[3]` = 1 (exclusive-or order), beat k carries the low window bits (start offset XOR k).
- R4: During a fixed burst the column bits above the burst window equal those of the start column on every beat.
- R5: A full-page burst counts up by one through the whole column range, wraps from the top column to 0, never raises `col_last`, and continues until `stop` is sampled high.
- R6: Full page together with `mode_word[3]` = 1 raises `mode_err` from the first beat and the burst runs in counting order; `mode_err` drops at the next start with any other setting.
- R7: With `mode_word[4]` = 1 every write (`is_write` = 1) is a single beat at the start column, while reads keep the programmed length and order; with `mode_word[4]` = 0 writes run the full length.
- R8: A length code of 100, 101 or 110 produces no valid beat and ends any burst in progress.
- R9: `stop` sampled high on a clock edge while a beat is shown ends the burst: `col_valid` is low from that edge on.
- R10: A start strobe during an active burst abandons it; the next cycle shows beat 0 of the new burst.
- R11: After reset `col_valid`, `col_last` and `mode_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst with the values below |
| mode_word | input | 5 | [2:0] length code, [3] order, [4] single-beat writes |
| start_col | input | COL_BITS | First column of the burst |
| is_write | input | 1 | 1 for a write burst, 0 for a read burst |
| stop | input | 1 | Terminate the burst in progress |
| col_out | output | COL_BITS | Column address of the current beat |
| col_valid | output | 1 | `col_out` holds a burst beat |
| col_last | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Full page was requested with exclusive-or order |

## Verification
On every cycle the assertions check that a terminate or a reserved code leaves no beat behind, that a start always yields beat 0 next, that a full-page burst never flags a last beat, that the window-external column bits hold still between beats, and that `col_last` never appears without a valid beat. The actual orderings, the beat counts per length, the wrap at the page top, the single-beat write reduction and the fallback to counting order under a mode error can only be shown by the bench's scenarios, which compare each beat against an address model built from the requirements.

// File: rtl/sdram_bag_pkg.sv
package sdram_bag_pkg;

   // length field codes of the mode word
   localparam logic [2:0] LEN_1    = 3'b000;
   localparam logic [2:0] LEN_2    = 3'b001;
   localparam logic [2:0] LEN_4    = 3'b010;
   localparam logic [2:0] LEN_8    = 3'b011;
   localparam logic [2:0] LEN_PAGE = 3'b111;

   // mode word bit positions
   localparam int MODE_W     = 5;
   localparam int ORDER_BIT  = 3;
   localparam int SWRITE_BIT = 4;

   // widest fixed burst window in column bits (8 beats)
   localparam int WIN_BITS = 3;

endpackage

// File: rtl/bag_mode_decode.sv
module bag_mode_decode
   import sdram_bag_pkg::*;
(
   input  logic [MODE_W-1:0]   mode_word,
   input  logic                is_write,
   output logic                reserved,
   output logic                full_page,
   output logic                use_xor,
   output logic                cfg_err,
   output logic [WIN_BITS-1:0] win_mask
);

   logic [2:0] len_code;
   logic       single_wr;

   assign len_code  = mode_word[2:0];
   assign single_wr = mode_word[SWRITE_BIT] & is_write;

   always_comb begin
      reserved  = 1'b0;
      full_page = 1'b0;
      win_mask  = '0;
      unique case (len_code)
         LEN_1:    win_mask = 3'b000;
         LEN_2:    win_mask = 3'b001;
         LEN_4:    win_mask = 3'b011;
         LEN_8:    win_mask = 3'b111;
         LEN_PAGE: full_page = 1'b1;
         default:  reserved = 1'b1;
      endcase
      // single-beat writes override the programmed length
      if (single_wr && !reserved) begin
         full_page = 1'b0;
         win_mask  = '0;
      end
      cfg_err = full_page & mode_word[ORDER_BIT];
      use_xor = mode_word[ORDER_BIT] & ~full_page & ~reserved;
   end

endmodule

// File: rtl/bag_col_order.sv
module bag_col_order #(
   parameter int COL_BITS = 9
) (
   input  logic [COL_BITS-1:0] base_col,
   input  logic [COL_BITS-1:0] beat_idx,
   input  logic [COL_BITS-1:0] col_mask,
   input  logic                use_xor,
   output logic [COL_BITS-1:0] col
);

   logic [COL_BITS-1:0] sum_col;
   logic [COL_BITS-1:0] xor_col;

   assign sum_col = base_col + beat_idx;
   assign xor_col = base_col ^ beat_idx;

   // per bit: inside the window take the moving value, outside keep the base
   for (genvar b = 0; b < COL_BITS; b++) begin : g_bit
      assign col[b] = col_mask[b] ? (use_xor ? xor_col[b] : sum_col[b]) : base_col[b];
   end

endmodule

// File: rtl/bag_beat_ctrl.sv
module bag_beat_ctrl
   import sdram_bag_pkg::*;
#(
   parameter int COL_BITS = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                stop,
   input  logic [COL_BITS-1:0] start_col,
   input  logic                reserved,
   input  logic                full_page,
   input  logic                use_xor,
   input  logic                cfg_err,
   input  logic [WIN_BITS-1:0] win_mask,
   output logic                active_q,
   output logic                last_beat,
   output logic                full_q,
   output logic                xor_q,
   output logic                err_q,
   output logic [COL_BITS-1:0] base_q,
   output logic [COL_BITS-1:0] idx_q,
   output logic [COL_BITS-1:0] mask_q
);

   logic [WIN_BITS-1:0] win_q;

   assign last_beat = active_q & ~full_q & (idx_q[WIN_BITS-1:0] == win_q);
   assign mask_q    = full_q ? {COL_BITS{1'b1}} : {{(COL_BITS-WIN_BITS){1'b0}}, win_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         full_q   <= 1'b0;
         xor_q    <= 1'b0;
         err_q    <= 1'b0;
         win_q    <= '0;
         base_q   <= '0;
         idx_q    <= '0;
      end else if (start) begin
         active_q <= ~reserved;
         full_q   <= full_page;
         xor_q    <= use_xor;
         err_q    <= cfg_err;
         win_q    <= win_mask;
         base_q   <= start_col;
         idx_q    <= '0;
      end else if (active_q) begin
         if (stop || last_beat) begin
            active_q <= 1'b0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   // R10
   restart_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !reserved |=> active_q && idx_q == '0);

   // R8
   reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && reserved |=> !active_q);

   // R9
   stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop && active_q && !start |=> !active_q);

   // R5
   page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_q && full_q |-> !last_beat);

endmodule

// File: rtl/sdram_burst_addr_gen.sv
module sdram_burst_addr_gen
   import sdram_bag_pkg::*;
#(
   parameter int COL_BITS = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [MODE_W-1:0]   mode_word,
   input  logic [COL_BITS-1:0] start_col,
   input  logic                is_write,
   input  logic                stop,
   output logic [COL_BITS-1:0] col_out,
   output logic                col_valid,
   output logic                col_last,
   output logic                mode_err
);

   localparam int PAGE_COLS = 1 << COL_BITS;

   if (COL_BITS != 8 && COL_BITS != 9 && COL_BITS != 10) begin : g_bad_width
      $error("sdram_burst_addr_gen: COL_BITS must be 8, 9 or 10 (page of %0d)", PAGE_COLS);
   end

   logic                reserved, full_page, use_xor, cfg_err;
   logic [WIN_BITS-1:0] win_mask;
   logic                active_q, last_beat, full_q, xor_q, err_q;
   logic [COL_BITS-1:0] base_q, idx_q, mask_q;

   bag_mode_decode u_decode (
      .mode_word (mode_word),
      .is_write  (is_write),
      .reserved  (reserved),
      .full_page (full_page),
      .use_xor   (use_xor),
      .cfg_err   (cfg_err),
      .win_mask  (win_mask)
   );

   bag_beat_ctrl #(.COL_BITS(COL_BITS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .stop      (stop),
      .start_col (start_col),
      .reserved  (reserved),
      .full_page (full_page),
      .use_xor   (use_xor),
      .cfg_err   (cfg_err),
      .win_mask  (win_mask),
      .active_q  (active_q),
      .last_beat (last_beat),
      .full_q    (full_q),
      .xor_q     (xor_q),
      .err_q     (err_q),
      .base_q    (base_q),
      .idx_q     (idx_q),
      .mask_q    (mask_q)
   );

   bag_col_order #(.COL_BITS(COL_BITS)) u_order (
      .base_col (base_q),
      .beat_idx (idx_q),
      .col_mask (mask_q),
      .use_xor  (xor_q),
      .col      (col_out)
   );

   assign col_valid = active_q;
   assign col_last  = last_beat;
   assign mode_err  = err_q;

   // R1
   last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_last |-> col_valid);

   // R4
   upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_valid && !full_q && $past(col_valid) && !$past(start)
      |-> (col_out & ~mask_q) == ($past(col_out) & ~$past(mask_q)));

endmodule

// File: tb/sdram_burst_addr_gen_tb.sv
module sdram_burst_addr_gen_tb_top;

   localparam int CB = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [4:0]    mode_word = '0;
   logic [CB-1:0] start_col = '0;
   logic          is_write = 1'b0;
   logic          stop = 1'b0;
   logic [CB-1:0] col_out;
   logic          col_valid, col_last, mode_err;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   sdram_burst_addr_gen #(.COL_BITS(CB)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_word(mode_word),
      .start_col(start_col), .is_write(is_write), .stop(stop),
      .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
      .mode_err(mode_err)
   );

   // {mode[4:0], col[8:0], write, beats[3:0]}
   localparam int NV = 8;
   localparam logic [18:0] VEC [NV] = '{
      {5'b00010, 9'h0A2, 1'b0, 4'd4},
      {5'b01011, 9'h1F5, 1'b0, 4'd8},
      {5'b00001, 9'h003, 1'b0, 4'd2},
      {5'b00000, 9'h055, 1'b1, 4'd1},
      {5'b00011, 9'h10E, 1'b0, 4'd8},
      {5'b01010, 9'h033, 1'b1, 4'd4},
      {5'b10011, 9'h0C4, 1'b1, 4'd1},
      {5'b10010, 9'h0C6, 1'b0, 4'd4}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // address model from the ordering requirements
   function automatic logic [CB-1:0] model_col(input logic [4:0] m, input logic [CB-1:0] c,
                                               input logic wr, input int k);
      logic [CB-1:0] mask;
      logic [CB-1:0] low;
      case (m[2:0])
         3'b001:  mask = 9'h001;
         3'b010:  mask = 9'h003;
         3'b011:  mask = 9'h007;
         3'b111:  mask = 9'h1FF;
         default: mask = 9'h000;
      endcase
      if (m[4] && wr) mask = '0;
      if (m[3] && m[2:0] != 3'b111) low = (c ^ CB'(k)) & mask;
      else                          low = (c + CB'(k)) & mask;
      return (c & ~mask) | low;
   endfunction

   task automatic kick(input logic [4:0] m, input logic [CB-1:0] c, input logic wr);
      mode_word = m; start_col = c; is_write = wr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      string tag;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 valid", col_valid, 0);
      chk("R11 last", col_last, 0);
      chk("R11 err", mode_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle after release", col_valid, 0);

      // vector table: R1 R2 R3 R4 R7
      for (int v = 0; v < NV; v++) begin
         logic [4:0]    m;
         logic [CB-1:0] c;
         logic          wr;
         int            n;
         m = VEC[v][18:14]; c = VEC[v][13:5]; wr = VEC[v][4]; n = int'(VEC[v][3:0]);
         if (m[4]) tag = "R7";
         else if (m[3]) tag = "R3";
         else tag = "R2";
         kick(m, c, wr);
         for (int k = 0; k < n; k++) begin
            chk(tag, col_out, model_col(m, c, wr, k));
            chk("R1 valid", col_valid, 1);
            chk("R1 last", col_last, (k == n - 1) ? 1 : 0);
            chk("R4 upper", col_out[CB-1:3] , (m[2:0] == 3'b000 || (m[4] && wr)) ?
                32'(col_out[CB-1:3]) : 32'(c[CB-1:3]));
            @(negedge clk);
         end
         chk("R1 ends", col_valid, 0);
         chk("R6 no err", mode_err, 0);
      end

      // R5 full page, counting, wraps at top of page
      kick(5'b00111, 9'h1FE, 1'b0);
      for (int k = 0; k < 6; k++) begin
         chk("R5 col", col_out, (9'h1FE + k) & 9'h1FF);
         chk("R5 no last", col_last, 0);
         if (k == 5) stop = 1'b1;
         @(negedge clk);
      end
      stop = 1'b0;
      chk("R9 stop ends page", col_valid, 0);

      // R6 full page with exclusive-or order runs counting order
      kick(5'b01111, 9'h005, 1'b0);
      chk("R6 err", mode_err, 1);
      for (int k = 0; k < 4; k++) begin
         chk("R6 col", col_out, 9'h005 + k);
         @(negedge clk);
      end
      chk("R6 still running", col_valid, 1);
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      kick(5'b00001, 9'h010, 1'b0);
      chk("R6 err cleared", mode_err, 0);
      repeat (3) @(negedge clk);

      // R7 normal write runs full length
      kick(5'b00010, 9'h041, 1'b1);
      for (int k = 0; k < 4; k++) begin
         chk("R7 normal write", col_out, model_col(5'b00010, 9'h041, 1'b1, k));
         @(negedge clk);
      end
      chk("R7 normal write ends", col_valid, 0);

      // R8 reserved code
      for (int r = 4; r < 7; r++) begin
         kick({2'b00, 3'(r)}, 9'h020, 1'b0);
         chk("R8 no beat", col_valid, 0);
      end
      kick(5'b00011, 9'h080, 1'b0);
      @(negedge clk);
      kick(5'b00100, 9'h020, 1'b0);
      chk("R8 aborts burst", col_valid, 0);

      // R9 early stop of a fixed burst
      kick(5'b00011, 9'h0F0, 1'b0);
      @(negedge clk);
      chk("R9 beat1", col_out, 9'h0F1);
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      chk("R9 stopped", col_valid, 0);
      chk("R9 no last", col_last, 0);

      // R10 restart during a burst
      kick(5'b00011, 9'h100, 1'b0);
      @(negedge clk);
      kick(5'b01010, 9'h0E6, 1'b0);
      for (int k = 0; k < 4; k++) begin
         chk("R10 new burst", col_out, model_col(5'b01010, 9'h0E6, 1'b0, k));
         chk("R10 last", col_last, (k == 3) ? 1 : 0);
         @(negedge clk);
      end
      chk("R10 ends", col_valid, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule